// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds three transmit mailboxes for a CAN controller and decides which loaded mailbox is handed next to a downstream frame transmitter. Software fills a mailbox through a simple word-wide register port: an identifier word, a length word and two data words. Setting the request bit of the identifier word queues the mailbox. The scheduler then offers the chosen mailbox's contents to the transmitter over a request/grant/done/error handshake.

The next mailbox is chosen by one of two rules, selected by a control bit. The first rule picks the most urgent identifier, which is the lowest arbitration value. The second rule picks the mailbox that was queued first. When a transfer finishes, the scheduler sets a per-mailbox completion flag in a status word. Software clears these flags by writing 1 to them. A single interrupt line combines the completion flags with an enable bit.

The sequencer has three states:
- IDLE leaves for OFFER when any mailbox is pending.
- OFFER drives `tx_req` with the currently selected mailbox. The selection is re-evaluated every cycle until `tx_grant`, at which point the sequencer moves to ACTIVE with the choice locked.
- ACTIVE returns to IDLE on `tx_done`, or on `tx_err`. On `tx_err` the mailbox stays queued when automatic retransmission is on.

Top module: `can_txmb_sched`

## Requirements
- R1: After reset, `tx_req` and `irq` are 0, and every register reads 0: control at address 0, status at address 1, interrupt enable at address 2, and all mailbox words.
- R2: Mailbox n occupies word addresses 4+4n (identifier), 5+4n (length), 6+4n (data low) and 7+4n (data high). The length word keeps only bits 3:0, which appear on `tx_len`; its other bits read back as 0. In the identifier word, bits 31:21 hold the standard ID, bits 31:3 hold the extended ID, bit 2 is the extended flag and bit 1 is the remote flag.
- R3: Writing an identifier word with bit 0 set to an empty mailbox queues that mailbox, and bit 0 then reads back as 1. Writing it with bit 0 clear stores the identifier but does not queue the mailbox.
- R4: When control bit 0 is 0, the pending mailbox with the smallest key wins. The key is {id[31:21], id[2], id[20:3] if id[2] is set, else zeros}. Equal keys go to the lowest mailbox index.
- R5: When control bit 0 is 1, pending mailboxes are served in the order in which they were queued.
- R6: On `tx_done` in ACTIVE, the request bit of the served mailbox clears and status bit 8n is set.
- R7: On `tx_err` with control bit 1 clear, the outcome is the same as R6. With control bit 1 set, the mailbox stays pending, no flag is set, and the mailbox is offered again.
- R8: Writing the status word clears exactly the completion flags at whose positions (0, 8, 16) a 1 is written.
- R9: `irq` is 1 exactly when interrupt-enable bit 0 is 1 and at least one completion flag is set.
- R10: Writes to any word of a pending mailbox have no effect.
- R11: While `tx_req` is 1, `tx_id`/`tx_len`/`tx_data0`/`tx_data1` carry the selected mailbox's contents, with `tx_id` bit 0 set. A grant locks that mailbox until done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| tx_req | output | 1 | Offer of a mailbox to the transmitter |
| tx_id | output | 32 | Identifier word of the offered mailbox |
| tx_len | output | 4 | Length code of the offered mailbox |
| tx_data0 | output | 32 | Data low word |
| tx_data1 | output | 32 | Data high word |
| tx_grant | input | 1 | Transmitter accepts the offer |
| tx_done | input | 1 | Transfer finished successfully |
| tx_err | input | 1 | Transfer failed |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is re-arbitration while an offer is open: the choice must change when a more urgent or older mailbox appears before the grant. The stimulus withholds `tx_grant` until all three mailboxes have been queued in a chosen order. It then grants and completes them one at a time from a table of vectors, checking the identifier presented at each offer against the expected service order.

Ties, standard versus extended frames with the same base identifier, and queue orders that differ from index order are covered by separate rows of that table. Writes made while a mailbox sits in OFFER check that a pending mailbox is locked.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_ACTIVE = 2'd2
    } txmb_state_e;

    localparam int KEY_W = 30;

    // Arbitration key: base ID, then the extended flag, then the extended
    // low part (zeroed for standard frames). A smaller key is more urgent.
    function automatic logic [KEY_W-1:0] arb_key(input logic [31:0] w);
        arb_key = {w[31:21], w[2], w[20:3] & {18{w[2]}}};
    endfunction

endpackage

// File: rtl/can_txmb_bank.sv
module can_txmb_bank #(
    parameter int MB_NUM  = 3,
    parameter int AW      = 4,
    parameter int MB_BASE = 4,
    localparam int RW     = (MB_NUM > 1) ? $clog2(MB_NUM) : 1,
    localparam int CW     = $clog2(MB_NUM + 1)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [AW-1:0]                wr_addr_i,
    input  logic [31:0]                  wr_data_i,
    input  logic [MB_NUM-1:0]            leave_i,
    output logic [MB_NUM-1:0][30:0]      id_o,
    output logic [MB_NUM-1:0][3:0]       len_o,
    output logic [MB_NUM-1:0][31:0]      d0_o,
    output logic [MB_NUM-1:0][31:0]      d1_o,
    output logic [MB_NUM-1:0]            pend_o,
    output logic [MB_NUM-1:0][RW-1:0]    rank_o
);

    logic [MB_NUM-1:0]         pend_q, pend_d, live, queue_v, hit_id;
    logic [MB_NUM-1:0][RW-1:0] rank_q, rank_d;
    logic [CW-1:0]             live_cnt;
    logic [RW-1:0]             leave_rank;

    for (genvar n = 0; n < MB_NUM; n++) begin : g_mb
        localparam logic [AW-1:0] A_ID  = AW'(MB_BASE + 4*n);
        localparam logic [AW-1:0] A_LEN = AW'(MB_BASE + 4*n + 1);
        localparam logic [AW-1:0] A_D0  = AW'(MB_BASE + 4*n + 2);
        localparam logic [AW-1:0] A_D1  = AW'(MB_BASE + 4*n + 3);

        assign hit_id[n]  = wr_en_i && (wr_addr_i == A_ID);
        assign queue_v[n] = hit_id[n] && wr_data_i[0] && !pend_q[n];

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                id_o[n]  <= '0;
                len_o[n] <= '0;
                d0_o[n]  <= '0;
                d1_o[n]  <= '0;
            end else if (wr_en_i && !pend_q[n]) begin
                if (wr_addr_i == A_ID)  id_o[n]  <= wr_data_i[31:1];
                if (wr_addr_i == A_LEN) len_o[n] <= wr_data_i[3:0];
                if (wr_addr_i == A_D0)  d0_o[n]  <= wr_data_i;
                if (wr_addr_i == A_D1)  d1_o[n]  <= wr_data_i;
            end
        end

        // R10
        locked_mb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pend_q[n] |=> ($stable(len_o[n]) && $stable(d0_o[n]) &&
                           $stable(d1_o[n]) && $stable(id_o[n])));
    end

    // Queue order bookkeeping: rank 0 is the oldest pending mailbox.
    always_comb begin
        live       = pend_q & ~leave_i;
        live_cnt   = '0;
        leave_rank = '0;
        for (int k = 0; k < MB_NUM; k++) begin
            live_cnt = live_cnt + CW'(live[k]);
            if (leave_i[k]) leave_rank = rank_q[k];
        end
        for (int k = 0; k < MB_NUM; k++) begin
            pend_d[k] = live[k];
            rank_d[k] = rank_q[k];
            if ((|leave_i) && live[k] && (rank_q[k] > leave_rank))
                rank_d[k] = rank_q[k] - RW'(1);
            if (queue_v[k]) begin
                pend_d[k] = 1'b1;
                rank_d[k] = RW'(live_cnt);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= '0;
            rank_q <= '0;
        end else begin
            pend_q <= pend_d;
            rank_q <= rank_d;
        end
    end

    assign pend_o = pend_q;
    assign rank_o = rank_q;

endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb
    import can_txmb_pkg::*;
#(
    parameter int MB_NUM = 3,
    localparam int RW    = (MB_NUM > 1) ? $clog2(MB_NUM) : 1
) (
    input  logic                      order_mode_i,
    input  logic [MB_NUM-1:0]         pend_i,
    input  logic [MB_NUM-1:0][30:0]   id_i,
    input  logic [MB_NUM-1:0][RW-1:0] rank_i,
    output logic [RW-1:0]             sel_o
);

    logic             found;
    logic [KEY_W-1:0] best_key, cand_key;
    logic [RW-1:0]    best_rank;

    always_comb begin
        found     = 1'b0;
        sel_o     = '0;
        best_key  = '0;
        best_rank = '0;
        cand_key  = '0;
        for (int n = 0; n < MB_NUM; n++) begin
            cand_key = arb_key({id_i[n], 1'b0});
            if (pend_i[n]) begin
                if (!found ||
                    ( order_mode_i && (rank_i[n] < best_rank)) ||
                    (!order_mode_i && (cand_key < best_key))) begin
                    found     = 1'b1;
                    sel_o     = RW'(n);
                    best_key  = cand_key;
                    best_rank = rank_i[n];
                end
            end
        end
    end

endmodule

// File: rtl/can_txmb_fsm.sv
module can_txmb_fsm
    import can_txmb_pkg::*;
#(
    parameter int MB_NUM = 3,
    localparam int RW    = (MB_NUM > 1) ? $clog2(MB_NUM) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MB_NUM-1:0] pend_i,
    input  logic [RW-1:0]     sel_i,
    input  logic              auto_retx_i,
    input  logic              tx_grant_i,
    input  logic              tx_done_i,
    input  logic              tx_err_i,
    output logic              tx_req_o,
    output logic [RW-1:0]     cur_o,
    output logic [MB_NUM-1:0] leave_o,
    output logic [MB_NUM-1:0] fin_o
);

    txmb_state_e   state_q, state_d;
    logic [RW-1:0] act_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_OFFER && tx_grant_i) act_q <= sel_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (|pend_i) state_d = ST_OFFER;
            ST_OFFER:  if (tx_grant_i) state_d = ST_ACTIVE;
            ST_ACTIVE: if (tx_done_i || tx_err_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tx_req_o = 1'b0;
        cur_o    = act_q;
        leave_o  = '0;
        fin_o    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OFFER: begin
                tx_req_o = 1'b1;
                cur_o    = sel_i;
            end
            ST_ACTIVE: begin
                if (tx_done_i || (tx_err_i && !auto_retx_i)) begin
                    leave_o = MB_NUM'(1) << act_q;
                    fin_o   = MB_NUM'(1) << act_q;
                end
            end
            default: ;
        endcase
    end

    // R11
    req_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_req_o |-> pend_i[cur_o]);

    // R4
    sel_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pend_i) |-> pend_i[sel_i]);

    // R6
    done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE && tx_done_i) |=> !pend_i[$past(act_q)]);

    // R7
    retry_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE && tx_err_i && !tx_done_i && auto_retx_i)
            |=> pend_i[$past(act_q)]);

endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched #(
    parameter int MB_NUM  = 3,
    parameter int AW      = 4,
    localparam int MB_BASE = 4,
    localparam int RW      = (MB_NUM > 1) ? $clog2(MB_NUM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          tx_req,
    output logic [31:0]   tx_id,
    output logic [3:0]    tx_len,
    output logic [31:0]   tx_data0,
    output logic [31:0]   tx_data1,
    input  logic          tx_grant,
    input  logic          tx_done,
    input  logic          tx_err,
    output logic          irq
);

    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_STAT = AW'(1);
    localparam logic [AW-1:0] A_IE   = AW'(2);

    logic                      order_mode_q, auto_retx_q, ie_q;
    logic [MB_NUM-1:0]         rc_q, rc_clr;
    logic [MB_NUM-1:0][30:0]   id_w;
    logic [MB_NUM-1:0][3:0]    len_w;
    logic [MB_NUM-1:0][31:0]   d0_w, d1_w;
    logic [MB_NUM-1:0]         pend, leave, fin;
    logic [MB_NUM-1:0][RW-1:0] rank;
    logic [RW-1:0]             sel, cur;

    can_txmb_bank #(.MB_NUM(MB_NUM), .AW(AW), .MB_BASE(MB_BASE)) u_bank (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .leave_i(leave), .id_o(id_w), .len_o(len_w),
        .d0_o(d0_w), .d1_o(d1_w), .pend_o(pend), .rank_o(rank)
    );

    can_txmb_arb #(.MB_NUM(MB_NUM)) u_arb (
        .order_mode_i(order_mode_q), .pend_i(pend), .id_i(id_w),
        .rank_i(rank), .sel_o(sel)
    );

    can_txmb_fsm #(.MB_NUM(MB_NUM)) u_fsm (
        .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .sel_i(sel),
        .auto_retx_i(auto_retx_q), .tx_grant_i(tx_grant), .tx_done_i(tx_done),
        .tx_err_i(tx_err), .tx_req_o(tx_req), .cur_o(cur), .leave_o(leave),
        .fin_o(fin)
    );

    always_comb begin
        for (int n = 0; n < MB_NUM; n++)
            rc_clr[n] = wr_en && (wr_addr == A_STAT) && wr_data[8*n];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_mode_q <= 1'b0;
            auto_retx_q  <= 1'b0;
            ie_q         <= 1'b0;
            rc_q         <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) begin
                order_mode_q <= wr_data[0];
                auto_retx_q  <= wr_data[1];
            end
            if (wr_en && wr_addr == A_IE) ie_q <= wr_data[0];
            rc_q <= (rc_q & ~rc_clr) | fin;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) rd_data[1:0] = {auto_retx_q, order_mode_q};
        if (rd_addr == A_IE)   rd_data[0]   = ie_q;
        for (int n = 0; n < MB_NUM; n++) begin
            if (rd_addr == A_STAT) rd_data[8*n] = rc_q[n];
            if (int'(rd_addr) == MB_BASE + 4*n)     rd_data = {id_w[n], pend[n]};
            if (int'(rd_addr) == MB_BASE + 4*n + 1) rd_data = {28'd0, len_w[n]};
            if (int'(rd_addr) == MB_BASE + 4*n + 2) rd_data = d0_w[n];
            if (int'(rd_addr) == MB_BASE + 4*n + 3) rd_data = d1_w[n];
        end
    end

    assign tx_id    = {id_w[cur], pend[cur]};
    assign tx_len   = len_w[cur];
    assign tx_data0 = d0_w[cur];
    assign tx_data1 = d1_w[cur];
    assign irq      = ie_q && (|rc_q);

    for (genvar n = 0; n < MB_NUM; n++) begin : g_chk
        // R6
        flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rc_q[n]) |-> $past(fin[n]));
        // R8
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rc_q[n]) |-> $past(rc_clr[n]));
    end

endmodule

// File: tb/sim_can_txmb_sched.sv
module sim_can_txmb_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tx_req, irq;
    logic [31:0] tx_id, tx_data0, tx_data1;
    logic [3:0]  tx_len;
    logic        tx_grant = 1'b0, tx_done = 1'b0, tx_err = 1'b0;

    int tests = 0;
    int fails = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    can_txmb_sched u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_req(tx_req), .tx_id(tx_id), .tx_len(tx_len), .tx_data0(tx_data0),
        .tx_data1(tx_data1), .tx_grant(tx_grant), .tx_done(tx_done),
        .tx_err(tx_err), .irq(irq)
    );

    typedef struct packed {
        logic        mode;
        logic [5:0]  q;      // queue order, {third, second, first}
        logic [95:0] w;      // identifier words, {mb2, mb1, mb0}
        logic [5:0]  e;      // expected service order, {third, second, first}
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, {2'd2,2'd1,2'd0}, {32'h40000000,32'h20000000,32'h60000000}, {2'd0,2'd2,2'd1}},
        '{1'b0, {2'd0,2'd1,2'd2}, {32'h0A000000,32'h0A000000,32'h0A000000}, {2'd2,2'd1,2'd0}},
        '{1'b1, {2'd1,2'd0,2'd2}, {32'h60000000,32'h40000000,32'h20000000}, {2'd1,2'd0,2'd2}},
        '{1'b0, {2'd2,2'd1,2'd0}, {32'hFFE00000,32'h24600000,32'h2460002C}, {2'd2,2'd0,2'd1}},
        '{1'b1, {2'd0,2'd2,2'd1}, {32'h00600000,32'h00400000,32'h00200000}, {2'd0,2'd2,2'd1}},
        '{1'b0, {2'd2,2'd1,2'd0}, {32'hFFE00000,32'h0000000C,32'h08000004}, {2'd2,2'd0,2'd1}}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = 4'(a);
        #1 d = rd_data;
    endtask

    task automatic wait_req(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            if (tx_req) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic serve(input bit as_err);
        tx_grant = 1'b1;
        @(negedge clk);
        tx_grant = 1'b0;
        if (as_err) tx_err = 1'b1; else tx_done = 1'b1;
        @(negedge clk);
        tx_err = 1'b0; tx_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_req", {31'd0, tx_req}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(0, r); chk("R1 ctrl", r, 32'd0);
        rd(1, r); chk("R1 status", r, 32'd0);
        rd(2, r); chk("R1 ie", r, 32'd0);
        rd(4, r); chk("R1 mb0 id", r, 32'd0);
        rd(15, r); chk("R1 mb2 data high", r, 32'd0);

        wr(2, 32'd1);

        // Vector table: R4/R5/R11/R6 service order and contents
        for (int v = 0; v < NV; v++) begin
            wr(0, {31'd0, VECS[v].mode});
            for (int k = 0; k < 3; k++) begin
                int m;
                m = int'(VECS[v].q[2*k +: 2]);
                wr(5 + 4*m, 32'(m + 5));
                wr(6 + 4*m, 32'hA0000000 | 32'(v << 8) | 32'(m));
                wr(7 + 4*m, ~(32'hA0000000 | 32'(v << 8) | 32'(m)));
                wr(4 + 4*m, VECS[v].w[32*m +: 32] | 32'd1);
            end
            for (int k = 0; k < 3; k++) begin
                int m;
                m = int'(VECS[v].e[2*k +: 2]);
                wait_req(seen);
                chk("R11 offer present", {31'd0, seen}, 32'd1);
                chk(VECS[v].mode ? "R5 order id" : "R4 priority id", tx_id,
                    VECS[v].w[32*m +: 32] | 32'd1);
                chk("R2 tx_len", {28'd0, tx_len}, 32'(m + 5));
                chk("R11 data low", tx_data0, 32'hA0000000 | 32'(v << 8) | 32'(m));
                chk("R11 data high", tx_data1, ~(32'hA0000000 | 32'(v << 8) | 32'(m)));
                serve(1'b0);
                rd(1, r); chk("R6 flag set", {31'd0, r[8*m]}, 32'd1);
                rd(4 + 4*m, r); chk("R6 request cleared", {31'd0, r[0]}, 32'd0);
            end
            rd(1, r); chk("R6 all flags", r, 32'h00010101);
            chk("R9 irq on", {31'd0, irq}, 32'd1);
            wr(1, 32'h00010101);
            rd(1, r); chk("R8 clear all", r, 32'd0);
            chk("R9 irq off", {31'd0, irq}, 32'd0);
        end

        // R3 write without request bit does not queue
        wr(0, 32'd0);
        wr(4, 32'h20000000);
        repeat (3) @(negedge clk);
        chk("R3 no queue", {31'd0, tx_req}, 32'd0);
        rd(4, r); chk("R3 id stored", r, 32'h20000000);

        // R2 length word keeps only bits 3:0
        wr(5, 32'hFFFFFFF3);
        rd(5, r); chk("R2 len readback", r, 32'd3);

        // R10 writes to a pending mailbox are ignored
        wr(6, 32'h11111111);
        wr(4, 32'h20000001);
        wait_req(seen);
        wr(6, 32'hDEADBEEF);
        wr(5, 32'd9);
        wr(4, 32'h40000001);
        rd(6, r); chk("R10 data kept", r, 32'h11111111);
        rd(5, r); chk("R10 len kept", r, 32'd3);
        rd(4, r); chk("R10 id kept", r, 32'h20000001);
        chk("R10 offered data", tx_data0, 32'h11111111);
        serve(1'b0);
        wr(1, 32'h1);

        // R7 error without retransmission
        wr(12, 32'h60000001);
        wait_req(seen);
        serve(1'b1);
        rd(12, r); chk("R7 err clears request", r, 32'h60000000);
        rd(1, r); chk("R7 err sets flag", r, 32'h00010000);
        repeat (3) @(negedge clk);
        chk("R7 no reoffer", {31'd0, tx_req}, 32'd0);

        // R7 error with retransmission
        wr(0, 32'd2);
        wr(8, 32'h20000001);
        wait_req(seen);
        serve(1'b1);
        rd(8, r); chk("R7 retx keeps request", r, 32'h20000001);
        rd(1, r); chk("R7 retx no flag", r, 32'h00010000);
        wait_req(seen);
        chk("R7 reoffered", {31'd0, seen}, 32'd1);
        chk("R7 reoffered id", tx_id, 32'h20000001);
        serve(1'b0);
        rd(1, r); chk("R7 retx then done", r, 32'h00010100);

        // R8 partial clear, R9 enable gating
        wr(1, 32'h00000100);
        rd(1, r); chk("R8 partial clear", r, 32'h00010000);
        wr(2, 32'd0);
        chk("R9 gated off", {31'd0, irq}, 32'd0);
        wr(2, 32'd1);
        chk("R9 enabled", {31'd0, irq}, 32'd1);
        wr(1, 32'hFFFFFFFF);
        chk("R9 no flags", {31'd0, irq}, 32'd0);

        finish_run();
    end

endmodule